// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Turn-On Dead Time

This block drives the four gate enables of an H-bridge: upper and lower switch of leg A, and upper and lower switch of leg B. One direction bit chooses the diagonal that conducts. A direction of 1 turns on the A-upper and B-lower switches. A direction of 0 turns on the A-lower and B-upper switches. A shutdown input turns every switch off. An upper-side permit input can hold both upper switches off while the lower pair keeps following direction, so load current freewheels through the bottom of the bridge.

Shoot-through is prevented by delay on turn-on only. Each output that is asked to turn on waits a programmable number of clock cycles before it asserts. Both upper switches share one delay setting, and both lower switches share a second setting. Turn-off takes no added delay. The direction bit, after synchronization, is also driven out on its own pin for outside feedback or hysteresis logic. All pins are plain control signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `hb_gate_seq`

## Requirements
- R1: With shutdown low and permit high, a synchronized direction of 1 gives ah_on=1, bl_on=1, al_on=0 and bh_on=0 once the delays have run.
- R2: With shutdown low and permit high, a synchronized direction of 0 gives al_on=1, bh_on=1, ah_on=0 and bl_on=0 once the delays have run.
- R3: A synchronized shutdown of 1 turns all four outputs off, whatever the other inputs are.
- R4: A synchronized permit of 0 turns ah_on and bh_on off. al_on and bl_on keep following direction.
- R5: An upper output asserts hi_dly cycles after its request begins. The request begins when the synchronized inputs call for that output. From an input pin change the output asserts at clock edge 3+hi_dly. Both upper outputs use this one setting.
- R6: A lower output asserts lo_dly cycles after its request begins. From an input pin change the output asserts at clock edge 3+lo_dly. Both lower outputs use this one setting.
- R7: An output turns off on the first edge after its request ends, with no dead time added. From a pin change this is edge 3.
- R8: A delay setting of 0 asserts the output on the same edge that first sees the request, which is edge 3 after the pin change.
- R9: The delay value is captured when a request begins. A change to hi_dly or lo_dly while that request is pending does not move its turn-on edge.
- R10: If a request ends before its delay has run out, the pending turn-on is dropped. The next request waits the full delay again.
- R11: ah_on and al_on are never both 1 in the same cycle. The same holds for bh_on and bl_on.
- R12: dir_in, shut_in and permit_in each pass through two flops. dir_echo shows direction two edges after a pin change. Out of reset the synchronizer holds shutdown=1, permit=1 and direction=0, so the outputs stay off until the real inputs arrive.
- R13: rst_n is an active-low synchronous reset. It turns all four outputs off on the next edge and clears both delay counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_in | input | 1 | Direction command, asynchronous |
| shut_in | input | 1 | Shutdown; 1 turns all outputs off |
| permit_in | input | 1 | Upper-side permit; 0 holds both upper outputs off |
| hi_dly | input | 8 | Turn-on delay for the upper outputs, in clock cycles |
| lo_dly | input | 8 | Turn-on delay for the lower outputs, in clock cycles |
| ah_on | output | 1 | Leg A upper gate enable |
| al_on | output | 1 | Leg A lower gate enable |
| bh_on | output | 1 | Leg B upper gate enable |
| bl_on | output | 1 | Leg B lower gate enable |
| dir_echo | output | 1 | Synchronized direction |

## Verification
The embedded properties check on every cycle the rules that hold cycle by cycle:
- leg exclusivity;
- the shutdown and permit overrides one cycle after the synchronized value;
- off on the edge after a request ends;
- zero delay giving turn-on on the first edge;
- the delay counter staying within its captured limit.

The bench scenarios show what needs history from the pins: exact turn-on edges counted from an input change for non-zero delays, capture of the delay at the start of a request, cancellation followed by a full restart, the reset defaults in the synchronizer, and the two-edge latency of the direction echo.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned DLY_W = 8;
  localparam int unsigned N_GATE = 4;

  // gate index order used across the block
  localparam int unsigned G_AH = 0;
  localparam int unsigned G_AL = 1;
  localparam int unsigned G_BH = 2;
  localparam int unsigned G_BL = 3;

  typedef struct packed {
    logic dir;
    logic shut;
    logic permit;
  } hb_ctl_t;

  localparam hb_ctl_t CTL_RST = '{dir: 1'b0, shut: 1'b1, permit: 1'b1};

  function automatic bit is_upper(int unsigned idx);
    return (idx == G_AH) || (idx == G_BH);
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hb_on_delay.sv
module hb_on_delay #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [DW-1:0] dly,
  output logic          on
);
  logic          armed;
  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;

  always_ff @(posedge clk) begin
    if (!rst_n || !req) begin
      on    <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
      lim   <= '0;
    end else if (!on) begin
      if (!armed) begin
        if (dly == '0) begin
          on <= 1'b1;
        end else begin
          armed <= 1'b1;
          lim   <= dly;
          cnt   <= DW'(1);
        end
      end else if (cnt == lim) begin
        on    <= 1'b1;
        armed <= 1'b0;
      end else begin
        cnt <= cnt + DW'(1);
      end
    end
  end

  AST_OFF_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !on); // R7
  AST_ZERO_DLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !on && !armed && dly == '0) |=> on); // R8
  AST_CNT_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt <= lim && cnt != '0)); // R10
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_pkg::*;
#(
  parameter int unsigned DW = DLY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_in,
  input  logic          shut_in,
  input  logic          permit_in,
  input  logic [DW-1:0] hi_dly,
  input  logic [DW-1:0] lo_dly,
  output logic          ah_on,
  output logic          al_on,
  output logic          bh_on,
  output logic          bl_on,
  output logic          dir_echo
);
  localparam int unsigned CW = $bits(hb_ctl_t);

  hb_ctl_t raw_ctl, syn_ctl;
  logic [CW-1:0] syn_bits;
  logic [N_GATE-1:0] req;
  logic [N_GATE-1:0] gate;

  assign raw_ctl = '{dir: dir_in, shut: shut_in, permit: permit_in};

  hb_sync #(.W(CW), .RST_VAL(CW'(CTL_RST))) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_ctl),
    .q    (syn_bits)
  );
  assign syn_ctl  = hb_ctl_t'(syn_bits);
  assign dir_echo = syn_ctl.dir;

  always_comb begin
    req       = '0;
    req[G_AH] = syn_ctl.dir  & syn_ctl.permit;
    req[G_AL] = ~syn_ctl.dir;
    req[G_BH] = ~syn_ctl.dir & syn_ctl.permit;
    req[G_BL] = syn_ctl.dir;
    if (syn_ctl.shut) req = '0;
  end

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    localparam bit UPPER = is_upper(g);
    logic [DW-1:0] sel_dly;
    if (UPPER) begin : g_hi
      assign sel_dly = hi_dly;
    end else begin : g_lo
      assign sel_dly = lo_dly;
    end
    hb_on_delay #(.DW(DW)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req[g]),
      .dly  (sel_dly),
      .on   (gate[g])
    );
  end

  assign ah_on = gate[G_AH];
  assign al_on = gate[G_AL];
  assign bh_on = gate[G_BH];
  assign bl_on = gate[G_BL];

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ah_on && al_on)); // R11
  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bh_on && bl_on)); // R11
  AST_SHUT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    syn_ctl.shut |=> !(ah_on || al_on || bh_on || bl_on)); // R3
  AST_PERMIT_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_ctl.permit |=> !(ah_on || bh_on)); // R4
  AST_RESET_OFF: assert property (@(posedge clk)
    !rst_n |=> !(ah_on || al_on || bh_on || bl_on)); // R13
endmodule

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_in = 1'b0, shut_in = 1'b1, permit_in = 1'b1;
  logic [7:0] hi_dly = '0, lo_dly = '0;
  logic ah_on, al_on, bh_on, bl_on, dir_echo;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hb_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .shut_in(shut_in),
    .permit_in(permit_in), .hi_dly(hi_dly), .lo_dly(lo_dly),
    .ah_on(ah_on), .al_on(al_on), .bh_on(bh_on), .bl_on(bl_on),
    .dir_echo(dir_echo)
  );

  // vector: {dir, shut, permit, exp ah, al, bh, bl}
  localparam logic [6:0] VEC [10] = '{
    7'b1_0_1_1001, 7'b0_0_1_0110, 7'b1_1_1_0000, 7'b0_1_0_0000,
    7'b1_0_0_0001, 7'b0_0_0_0100, 7'b0_0_1_0110, 7'b1_0_1_1001,
    7'b1_1_0_0000, 7'b0_0_1_0110
  };

  function automatic logic [3:0] outs();
    return {ah_on, al_on, bh_on, bl_on};
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    step(3);
    chk("R13 outputs off in reset", outs(), 4'b0000);
    // R12: synchronizer defaults hold outputs off after reset release
    shut_in = 1'b0; dir_in = 1'b0; permit_in = 1'b1;
    rst_n = 1'b1;
    step(2);
    chk("R12 shutdown default after reset", outs(), 4'b0000);
    step(1);
    chk("R12 R2 real inputs arrive edge 3", outs(), 4'b0110);

    // R1 R2 R3 R4 vector table, zero delays
    foreach (VEC[i]) begin
      dir_in = VEC[i][6]; shut_in = VEC[i][5]; permit_in = VEC[i][4];
      step(4);
      chk($sformatf("R1 R2 R3 R4 vector %0d", i), outs(), VEC[i][3:0]);
    end

    // R12 echo latency
    dir_in = 1'b1;
    step(1);
    chk("R12 echo old after 1 edge", {3'b0, dir_echo}, 4'b0000);
    step(1);
    chk("R12 echo new after 2 edges", {3'b0, dir_echo}, 4'b0001);
    dir_in = 1'b0; step(4);

    // R5 R6 R7: hi=5 lo=3, dir 0->1
    hi_dly = 8'd5; lo_dly = 8'd3; dir_in = 1'b1;
    step(2);
    chk("R7 still on at edge 2", outs(), 4'b0110);
    step(1);
    chk("R7 turn-off at edge 3", outs(), 4'b0000);
    step(2);
    chk("R6 lower not yet at edge 5", outs(), 4'b0000);
    step(1);
    chk("R6 lower on at edge 6", outs(), 4'b0001);
    step(1);
    chk("R5 upper not yet at edge 7", outs(), 4'b0001);
    step(1);
    chk("R5 upper on at edge 8", outs(), 4'b1001);
    // R5 shared setting on leg B upper
    dir_in = 1'b0;
    step(7);
    chk("R5 B upper not yet at edge 7", outs(), 4'b0100);
    step(1);
    chk("R5 B upper on at edge 8", outs(), 4'b0110);

    // R9: delay captured at request start
    hi_dly = 8'd4; lo_dly = 8'd0; dir_in = 1'b1;
    step(3);
    hi_dly = 8'd20;
    step(3);
    chk("R9 upper not yet at edge 6", outs(), 4'b0001);
    step(1);
    chk("R9 upper on at edge 7 despite change", outs(), 4'b1001);

    // R10: cancel then full restart
    dir_in = 1'b0; hi_dly = 8'd10; step(6);
    dir_in = 1'b1; step(5);
    dir_in = 1'b0; step(5);
    chk("R10 cancelled request never turned on", outs(), 4'b0100);
    dir_in = 1'b1;
    step(12);
    chk("R10 restarted request waits full delay", outs(), 4'b0001);
    step(1);
    chk("R10 restarted request on at edge 13", outs(), 4'b1001);

    // R11 R3 with delays pending
    hi_dly = 8'd2; lo_dly = 8'd2; shut_in = 1'b1;
    step(3);
    chk("R3 shutdown turns all off", outs(), 4'b0000);
    shut_in = 1'b0; dir_in = 1'b0;
    step(5);
    chk("R11 R6 leg A lower only after delay", outs(), 4'b0110);

    // R13 reset mid-operation
    rst_n = 1'b0;
    step(1);
    chk("R13 synchronous reset turns all off", outs(), 4'b0000);
    rst_n = 1'b1;
    step(2);
    chk("R13 R12 defaults hold off after reset", outs(), 4'b0000);
    finish_run();
  end
endmodule